// File: doc/BRIEF.md
# Inverted-Load Up-Counting Frequency Divider

This block is the programmable divider in the feedback path of a frequency synthesizer loop. It runs on the prescaled oscillator clock and gives one output pulse per division period. The phase comparator checks that pulse against a fixed reference. The prescaler divides by eight and the reference runs at 12.5 kHz, so one step of the division ratio moves the oscillator by 100 kHz.

The divider does not use a down counter. It uses a 12-bit counter that counts upward. Each time the counter reaches all ones, it restarts from the bitwise inverse of a held division word. The counter therefore passes through one value more than the word states, and the division ratio is the word plus one. To get a ratio of N, software writes N-1. A write strobe copies a new word into the holding register. The counter picks up the new word only at its next restart, so the running period is never cut short.

A two-state sequencer tracks the counter. In state COUNTING the counter increments. In state TERMINAL the counter holds all ones and the output pulse is high. The sequencer has four transitions:
- ADVANCE: COUNTING to COUNTING, when the counter is below all ones minus one.
- ARRIVE: COUNTING to TERMINAL, when the counter is at all ones minus one.
- RESTART: TERMINAL to COUNTING, when the reload value is not all ones.
- REPEAT: TERMINAL to TERMINAL, when the word is zero, so the reload value is all ones.

A synchronous reset behaves like a restart. It takes the division word present on the input and enters TERMINAL if that word is zero, or COUNTING otherwise.

Top module: `pdiv_top`

## Requirements
- R1: While reset is high at a clock edge, the block copies the input word L into its holding register and loads the counter with the inverse of L. After the reset edge, the first pulse appears after exactly L further clock edges.
- R2: With a held word L (from 1 to 4095), consecutive output pulses are exactly L+1 clock cycles apart.
- R3: For any held word other than zero, each pulse is high for exactly one clock cycle, namely the cycle in which the counter is all ones. At the following edge the counter reloads the inverse of the held word.
- R4: A word written while the counter is mid-period does not change the length of that period. The next period uses the new word.
- R5: A word written during the pulse cycle does not affect the reload at that cycle's edge. It first takes effect at the reload after that.
- R6: With a held word of zero, the output pulse stays high continuously, which is a ratio of one.
- R7: With a held word of 4095, the pulse period is 4096 cycles.
- R8: A change on the word input while the write strobe is low has no effect on the pulse period.
- R9: A word of 981 gives a period of 982 cycles (98.2 MHz oscillator), and a word of 1192 gives 1193 cycles (119.3 MHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled oscillator clock |
| rst | input | 1 | Synchronous reset; captures div_word and loads the counter with its inverse |
| div_word | input | 12 | Division word, equal to the ratio minus one |
| word_wr | input | 1 | Write strobe that copies div_word into the holding register |
| div_pulse | output | 1 | One-cycle pulse per division period, to the phase comparator |

## Verification
The hardest case to reach from the ports is a word written in the same cycle as the pulse. At that edge the old word must drive the reload while the new word is captured. To reach it, the bench waits until it sees the pulse just after an edge, raises the strobe in that same cycle, and then measures two further periods: the first must still follow the old word and the second the new one. A mid-period write and a word change without the strobe are measured in the same way, by counting the cycles between pulses.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    typedef enum logic {
        ST_COUNTING = 1'b0,
        ST_TERMINAL = 1'b1
    } div_state_e;
endpackage

// File: rtl/pdiv_word_hold.sv
module pdiv_word_hold #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] held_o
);
    always_ff @(posedge clk) begin
        if (rst || wr_i) begin
            held_o <= word_i;
        end
    end

    // R8
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(held_o));
endmodule

// File: rtl/pdiv_up_counter.sv
module pdiv_up_counter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             near_top_o
);
    localparam logic [WIDTH-1:0] TOP      = '1;
    localparam logic [WIDTH-1:0] NEAR_TOP = TOP - WIDTH'(1);

    always_ff @(posedge clk) begin
        if (load_i) begin
            cnt_o <= ~seed_i;
        end else begin
            cnt_o <= cnt_o + WIDTH'(1);
        end
    end

    assign near_top_o = (cnt_o == NEAR_TOP);
endmodule

// File: rtl/pdiv_phase_fsm.sv
module pdiv_phase_fsm
    import pdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       near_top_i,
    input  logic       seed_zero_i,
    output div_state_e state_o,
    output logic       pulse_o
);
    div_state_e state_q;
    div_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= seed_zero_i ? ST_TERMINAL : ST_COUNTING;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNTING: state_d = near_top_i  ? ST_TERMINAL : ST_COUNTING;
            ST_TERMINAL: state_d = seed_zero_i ? ST_TERMINAL : ST_COUNTING;
        endcase
    end

    always_comb begin
        pulse_o = (state_q == ST_TERMINAL);
    end

    assign state_o = state_q;

    // R6
    zero_word_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && seed_zero_i) |=> pulse_o);
endmodule

// File: rtl/pdiv_top.sv
module pdiv_top
    import pdiv_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] div_word,
    input  logic             word_wr,
    output logic             div_pulse
);
    logic [WIDTH-1:0] held;
    logic [WIDTH-1:0] seed;
    logic [WIDTH-1:0] cnt;
    logic             near_top;
    logic             seed_zero;
    div_state_e       state;

    assign seed      = rst ? div_word : held;
    assign seed_zero = (seed == '0);

    pdiv_word_hold #(.WIDTH(WIDTH)) hold_i (
        .clk(clk), .rst(rst), .wr_i(word_wr), .word_i(div_word), .held_o(held)
    );

    pdiv_phase_fsm fsm_i (
        .clk(clk), .rst(rst), .near_top_i(near_top), .seed_zero_i(seed_zero),
        .state_o(state), .pulse_o(div_pulse)
    );

    pdiv_up_counter #(.WIDTH(WIDTH)) cnt_i (
        .clk(clk), .load_i(rst || (state == ST_TERMINAL)), .seed_i(seed),
        .cnt_o(cnt), .near_top_o(near_top)
    );

    // R3
    pulse_at_top_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> (cnt == '1));

    // R3
    reload_inverse_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> (cnt == ~$past(held)));

    // R2
    run_increment_chk: assert property (@(posedge clk) disable iff (rst)
        !div_pulse |=> (cnt == $past(cnt) + WIDTH'(1)));
endmodule

// File: tb/pdiv_top_tb_top.sv
module pdiv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] div_word = 12'd5;
    logic        word_wr = 1'b0;
    logic        div_pulse;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    localparam int NVEC = 6;
    localparam logic [11:0] VEC_WORD [NVEC] = '{12'd1, 12'd2, 12'd7, 12'd981, 12'd1192, 12'd4095};
    localparam int          VEC_GAP  [NVEC] = '{2, 3, 8, 982, 1193, 4096};

    always #4 clk = ~clk;

    pdiv_top dut_i (
        .clk(clk), .rst(rst), .div_word(div_word), .word_wr(word_wr), .div_pulse(div_pulse)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reset_with(input logic [11:0] w);
        rst = 1'b1;
        div_word = w;
        tick();
        rst = 1'b0;
    endtask

    task automatic ticks_to_pulse(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!div_pulse && n < 5000);
    endtask

    initial begin
        int n;
        int hi;
        reset_with(12'd5);
        check("R1 pulse low after reset", int'(div_pulse), 0);
        ticks_to_pulse(n);
        check("R1 edges to first pulse", n, 5);
        tick();
        check("R3 pulse one cycle", int'(div_pulse), 0);

        for (int i = 0; i < NVEC; i++) begin
            reset_with(VEC_WORD[i]);
            ticks_to_pulse(n);
            check("R1 first pulse", n, int'(VEC_WORD[i]));
            ticks_to_pulse(n);
            check("R2 R7 R9 period", n, VEC_GAP[i]);
        end

        reset_with(12'd0);
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            if (div_pulse) hi++;
            tick();
        end
        check("R6 zero word constant high", hi, 10);

        reset_with(12'd10);
        ticks_to_pulse(n);
        tick(); tick(); tick();
        div_word = 12'd20;
        word_wr = 1'b1;
        tick();
        word_wr = 1'b0;
        div_word = 12'd0;
        ticks_to_pulse(n);
        check("R4 current period kept", n + 4, 11);
        ticks_to_pulse(n);
        check("R4 new word next period", n, 21);

        div_word = 12'd30;
        word_wr = 1'b1;
        ticks_to_pulse(n);
        word_wr = 1'b0;
        check("R5 write in pulse cycle deferred", n, 21);
        ticks_to_pulse(n);
        check("R5 write applies after", n, 31);

        div_word = 12'd100;
        ticks_to_pulse(n);
        check("R8 no strobe ignored", n, 31);
        ticks_to_pulse(n);
        check("R8 still old period", n, 31);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule